// File: doc/BRIEF.md
# Handshaked Synchronous Serial Port

This block is one serial channel whose bit clock always comes from outside the chip. The core writes a word into a parallel transmit holding register. The port then raises an output request and waits for the far end to assert its output enable. It drives one bit per falling edge of the external clock. When the frame is complete it releases the data line to high impedance. In the same way, the receive half takes in one bit on each rising edge of the external clock while the far end holds the input enable. When the word is complete, it latches the word into a parallel register and acknowledges it.

The frame length can be 8 or 16 bits, and the bit order can be most-significant first or least-significant first. The serial clock, both enables and the serial input go through one shared two-flop synchroniser, so they stay aligned with one another. Edge strobes are then taken from the synchronised clock. For that reason, each phase of the serial clock must last at least two core clock periods. The core sees a transmit-empty flag and a receive-full flag. The output-enable pair models the three-state data line.

Top module: `ssp_port`

## Requirements
- R1: After synchronous reset, tx_empty is 1, while out_req, sdo_oe, sdo, rx_full, in_ack and rx_data are all 0.
- R2: The transmit data line changes only after a synchronised falling edge of sck. After a load, sdo_oe stays 0 until the first such falling edge.
- R3: frame_wide=0 selects 8-bit frames and frame_wide=1 selects 16-bit frames. An 8-bit frame sends bits 7..0 of the written word, and it is received into bits 7..0 of rx_data with bits 15..8 equal to 0.
- R4: lsb_first=1 sends and stores bit 0 first. lsb_first=0 sends and stores the top bit of the frame first (bit 7 or bit 15).
- R5: A tx_wr pulse while tx_empty=1 loads tx_wdata and the current configuration. On the next cycle tx_empty is 0 and out_req is 1. A tx_wr pulse while tx_empty=0 is ignored and does not change the word being sent.
- R6: A falling edge of sck drives the next transmit bit only while out_en is 1. At a falling edge with out_en at 0, sdo and the bit position are held.
- R7: On the first rising edge of sck after the last bit has been driven, out_req falls, sdo_oe falls (high impedance) and tx_empty rises.
- R8: A receive bit is sampled from sdi at a rising edge of sck only while in_en is 1. Rising edges with in_en at 0 neither sample a bit nor advance the bit position.
- R9: When the last bit of a frame is sampled, rx_data takes the completed word, rx_full is set and in_ack is asserted. in_ack stays 1 until the next falling edge of sck.
- R10: A rx_rd pulse clears rx_full and leaves rx_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | External serial bit clock |
| frame_wide | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| lsb_first | input | 1 | 1 sends bit 0 first, 0 sends the top bit first |
| tx_wr | input | 1 | Core write strobe for the transmit word |
| tx_wdata | input | 16 | Transmit word |
| tx_empty | output | 1 | Transmit holding register is free |
| out_req | output | 1 | Request to the far end to enable the output |
| out_en | input | 1 | Output enable from the far end |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo (0 means high impedance) |
| in_en | input | 1 | Input enable from the far end |
| sdi | input | 1 | Serial data in |
| in_ack | output | 1 | Acknowledge of a completed received word |
| rx_rd | input | 1 | Core read strobe for the receive word |
| rx_data | output | 16 | Last completed received word |
| rx_full | output | 1 | An unread word is waiting |

## Verification
The hardest states to reach are frames that stop partway. In these states the enable drops for a few serial clock cycles while the clock keeps running. The port must then keep both the transmit line and the receive bit position frozen, and resume the frame exactly where it stopped. The bench reaches this state by removing both enables at a falling edge in the middle of a frame, running two idle serial cycles with inverted garbage on sdi, and then finishing the frame. A second directed frame issues a core write in the middle of a frame. The sweeps cover every 8-bit value in both bit orders and a spread of 16-bit words, sending and receiving at the same time.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W  = 16;
    localparam int SHORT_W = 8;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int POS_W   = $clog2(WORD_W);

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } order_e;

    typedef struct packed {
        logic   wide;
        order_e order;
    } frame_cfg_t;

    // Lines sampled from the serial side, synchronised as one group
    typedef struct packed {
        logic sck;
        logic oen;
        logic ien;
        logic din;
    } line_t;

    function automatic logic [CNT_W-1:0] frame_bits(input frame_cfg_t c);
        return c.wide ? CNT_W'(WORD_W) : CNT_W'(SHORT_W);
    endfunction

    // Word bit position carried by serial bit number cnt
    function automatic logic [POS_W-1:0] bit_pos(input frame_cfg_t c,
                                                 input logic [CNT_W-1:0] cnt);
        logic [CNT_W-1:0] t;
        if (c.order == ORDER_LSB) t = cnt;
        else                      t = frame_bits(c) - cnt - CNT_W'(1);
        return t[POS_W-1:0];
    endfunction

endpackage

// File: rtl/ssp_line_sync.sv
module ssp_line_sync
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t raw,
    output line_t cur,
    output logic  rise,
    output logic  fall
);
    line_t meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign rise = sync_q.sck & ~prev_q.sck;
    assign fall = ~sync_q.sck & prev_q.sck;

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_cfg_t        cfg_in,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              en,
    output logic              empty,
    output logic              req,
    output logic              sdo,
    output logic              oe
);
    typedef enum logic { TX_IDLE, TX_BUSY } tx_state_e;

    tx_state_e         state_q;
    frame_cfg_t        cfg_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_out;

    assign last_out = (cnt_q == frame_bits(cfg_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            cfg_q   <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            req     <= 1'b0;
            sdo     <= 1'b0;
            oe      <= 1'b0;
        end else begin
            case (state_q)
                TX_IDLE: if (wr) begin
                    word_q  <= wdata;
                    cfg_q   <= cfg_in;
                    cnt_q   <= '0;
                    req     <= 1'b1;
                    state_q <= TX_BUSY;
                end
                TX_BUSY: begin
                    if (fall && en && !last_out) begin
                        sdo   <= word_q[bit_pos(cfg_q, cnt_q)];
                        oe    <= 1'b1;
                        cnt_q <= cnt_q + CNT_W'(1);
                    end else if (rise && last_out) begin
                        oe      <= 1'b0;
                        req     <= 1'b0;
                        state_q <= TX_IDLE;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign empty = (state_q == TX_IDLE);

    // R7
    oe_within_req_chk: assert property (@(posedge clk) disable iff (rst)
        oe |-> req);
    // R6
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe) && !$past(fall)) |-> $stable(sdo));
    // R5
    load_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(empty) |-> $past(wr));

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_cfg_t        cfg_in,
    input  logic              rise,
    input  logic              fall,
    input  logic              en,
    input  logic              din,
    input  logic              rd,
    output logic [WORD_W-1:0] data,
    output logic              full,
    output logic              ack
);
    frame_cfg_t        cfg_q, act_cfg;
    logic [WORD_W-1:0] acc_q, nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              take, done;

    always_comb begin
        act_cfg = (cnt_q == '0) ? cfg_in : cfg_q;
        nxt     = (cnt_q == '0) ? '0 : acc_q;
        nxt[bit_pos(act_cfg, cnt_q)] = din;
    end

    assign take = rise && en;
    assign done = take && ((cnt_q + CNT_W'(1)) == frame_bits(act_cfg));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            acc_q <= '0;
            cnt_q <= '0;
            data  <= '0;
            full  <= 1'b0;
            ack   <= 1'b0;
        end else begin
            if (rd) full <= 1'b0;
            if (take) begin
                if (cnt_q == '0) cfg_q <= cfg_in;
                acc_q <= nxt;
                if (done) begin
                    data  <= nxt;
                    full  <= 1'b1;
                    ack   <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (fall) begin
                ack <= 1'b0;
            end
        end
    end

    // R9
    ack_with_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> ack);
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> (cnt_q < frame_bits(cfg_q)));
    // R10
    clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> $past(rd));

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        frame_wide,
    input  logic        lsb_first,
    input  logic        tx_wr,
    input  logic [15:0] tx_wdata,
    output logic        tx_empty,
    output logic        out_req,
    input  logic        out_en,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic        in_en,
    input  logic        sdi,
    output logic        in_ack,
    input  logic        rx_rd,
    output logic [15:0] rx_data,
    output logic        rx_full
);
    line_t      raw_l, cur_l;
    logic       rise_s, fall_s;
    frame_cfg_t cfg;

    assign raw_l = '{sck: sck, oen: out_en, ien: in_en, din: sdi};
    assign cfg   = '{wide: frame_wide, order: order_e'(lsb_first)};

    ssp_line_sync sync_i (
        .clk (clk), .rst (rst), .raw (raw_l), .cur (cur_l),
        .rise(rise_s), .fall(fall_s)
    );

    ssp_tx tx_i (
        .clk  (clk), .rst (rst), .cfg_in(cfg), .wr(tx_wr), .wdata(tx_wdata),
        .rise (rise_s), .fall(fall_s), .en(cur_l.oen),
        .empty(tx_empty), .req(out_req), .sdo(sdo), .oe(sdo_oe)
    );

    ssp_rx rx_i (
        .clk (clk), .rst(rst), .cfg_in(cfg), .rise(rise_s), .fall(fall_s),
        .en  (cur_l.ien), .din(cur_l.din), .rd(rx_rd),
        .data(rx_data), .full(rx_full), .ack(in_ack)
    );

endmodule

// File: tb/ssp_port_tb_top.sv
module ssp_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b1;
    logic        frame_wide = 1'b0, lsb_first = 1'b0;
    logic        tx_wr = 1'b0, out_en = 1'b0, in_en = 1'b0, sdi = 1'b0, rx_rd = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_empty, out_req, sdo, sdo_oe, in_ack, rx_full;
    logic [15:0] rx_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssp_port dut_i (
        .clk(clk), .rst(rst), .sck(sck), .frame_wide(frame_wide),
        .lsb_first(lsb_first), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_empty(tx_empty), .out_req(out_req), .out_en(out_en), .sdo(sdo),
        .sdo_oe(sdo_oe), .in_en(in_en), .sdi(sdi), .in_ack(in_ack),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame, sending tw and receiving rw at the same time.
    // pause_at >= 0 idles both enables for two sck cycles before that bit.
    // poke issues a core write in the middle of the frame.
    task automatic frame(input bit wide, input bit lsb, input logic [15:0] tw,
                         input logic [15:0] rw, input int pause_at, input bit poke);
        int n;
        logic [15:0] got, exp_t, exp_r;
        bit oe_all;
        logic held;
        n = wide ? 16 : 8;
        got = '0;
        oe_all = 1'b1;
        exp_t = wide ? tw : {8'h00, tw[7:0]};
        exp_r = wide ? rw : {8'h00, rw[7:0]};
        frame_wide = wide; lsb_first = lsb; tx_wdata = tw; tx_wr = 1'b1;
        clks(1);
        tx_wr = 1'b0;
        chk(tx_empty == 1'b0, "R5 load clears tx_empty", tx_empty, 0);
        chk(out_req == 1'b1, "R5 load raises out_req", out_req, 1);
        chk(sdo_oe == 1'b0, "R2 no drive before first fall", sdo_oe, 0);
        out_en = 1'b1; in_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (pause_at == i) begin
                out_en = 1'b0; in_en = 1'b0;
                held = sdo;
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b0; sdi = ~sdi; clks(4);
                    sck = 1'b1; clks(4);
                end
                chk(sdo == held, "R6 sdo held while out_en low", sdo, held);
                chk(out_req == 1'b1, "R6 request kept during pause", out_req, 1);
                out_en = 1'b1; in_en = 1'b1;
            end
            sck = 1'b0;
            sdi = lsb ? rw[i] : rw[n-1-i];
            clks(4);
            if (i == 0)
                chk(in_ack == 1'b0, "R9 in_ack cleared by falling edge", in_ack, 0);
            if (poke && i == 2) begin
                tx_wdata = ~tw; tx_wr = 1'b1; clks(1); tx_wr = 1'b0;
            end
            if (!sdo_oe) oe_all = 1'b0;
            got[lsb ? i : n-1-i] = sdo;
            sck = 1'b1;
            clks(4);
        end
        chk(oe_all, "R6 sdo driven through frame", oe_all, 1);
        chk(got == exp_t, lsb ? "R4 tx word lsb-first" : "R3 tx word msb-first", got, exp_t);
        chk(out_req == 1'b0, "R7 out_req released", out_req, 0);
        chk(sdo_oe == 1'b0, "R7 sdo high impedance", sdo_oe, 0);
        chk(tx_empty == 1'b1, "R7 tx_empty set", tx_empty, 1);
        chk(rx_full == 1'b1, "R9 rx_full set", rx_full, 1);
        chk(in_ack == 1'b1, "R9 in_ack asserted", in_ack, 1);
        chk(rx_data == exp_r, "R8 rx word", rx_data, exp_r);
        out_en = 1'b0; in_en = 1'b0;
        rx_rd = 1'b1; clks(1); rx_rd = 1'b0;
        chk(rx_full == 1'b0, "R10 rx_rd clears rx_full", rx_full, 0);
        chk(rx_data == exp_r, "R10 rx_data kept after read", rx_data, exp_r);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clks(3);
        rst = 1'b0;
        clks(1);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(out_req == 1'b0, "R1 out_req", out_req, 0);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1 sdo/sdo_oe", {sdo_oe, sdo}, 0);
        chk(rx_full == 1'b0 && in_ack == 1'b0, "R1 rx flags", {rx_full, in_ack}, 0);
        chk(rx_data == 16'h0, "R1 rx_data", rx_data, 0);
        clks(4);
        // R3 R4: every 8-bit value, both orders, upper byte must be dropped
        for (int o = 0; o < 2; o++)
            for (int v = 0; v < 256; v++)
                frame(1'b0, o[0], {~v[7:0], v[7:0]},
                      16'(v * 16'h0101) ^ 16'h3c96, -1, 1'b0);
        // R3 R4: 16-bit words spread over the range, both orders
        for (int o = 0; o < 2; o++)
            for (int k = 0; k < 64; k++)
                frame(1'b1, o[0], 16'(k * 16'h0403) ^ 16'h8001,
                      ~(16'(k * 16'h1111) ^ 16'h0f0f), -1, 1'b0);
        // R6 R8: pause partway through frames
        frame(1'b0, 1'b0, 16'h00a5, 16'h005c, 3, 1'b0);
        frame(1'b1, 1'b1, 16'hb3c1, 16'h7e18, 9, 1'b0);
        // R5: write while busy is ignored
        frame(1'b1, 1'b0, 16'h1234, 16'hfedc, -1, 1'b1);
        frame(1'b0, 1'b1, 16'h0069, 16'h0096, -1, 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule